// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block resolves one virtual page by walking a hashed page table kept in memory. The caller supplies a hash value, a 30-bit compare tag, a table base address, a table mask, a protection key, a no-execute flag and the kind of access wanted. The block then reads page table entries one word at a time through a single-outstanding memory read port, and reports one result.

Each hash value selects a primary group of eight two-word entries. The complement of the hash selects a secondary group. The block scans the primary group from entry 0 upward and stops at the first entry that matches. Only when no primary entry matches at all does it scan the secondary group the same way. A matching entry that denies the requested access ends the search with a protection fault; the other group is never consulted. The result is a one-cycle done pulse carrying a status, the matched entry's second word, and the rights computed from it.

Segment lookup, the hash function, any translation cache and referenced/changed bit updates are handled elsewhere.

Top module: `hpt_group_search`

## Requirements
- R1: A synchronous active-low reset leaves the block idle, with `req_ready_o` high and `done_o` low.
- R2: Word w (0 or 1) of entry i in the group selected by hash value g is read at `tbl_base_i + ((g & tbl_mask_i) << 6) + 8*i + 4*w`. Entries are read in index order 0 to 7, with word 0 read before word 1 of each entry.
- R3: The primary group uses `hash_i`, and the secondary group uses `~hash_i`. The secondary group is read only after all 8 primary entries have been found not to match.
- R4: An entry matches only if all of these hold: word 0 bit 31 (valid) is 1; word 0 bit 6 (group flag) is 0 in the primary scan and 1 in the secondary scan; and `{word0[30:7], word0[5:0]}` equals `tag_i`.
- R5: The scan stops at the first matching entry. No later entry is read, and `pte1_o` returns word 1 of that first matching entry.
- R6: Rights in `prot_o` are {exec, write, read} (bit 2, bit 1, bit 0), computed from the PP field in word 1 bits 1:0.
  - With key 0, PP values 0, 1 and 2 give read and write, and PP 3 gives read only.
  - With key 1, PP 0 gives nothing, PP 1 and 3 give read only, and PP 2 gives read and write.
  - Exec is granted exactly when read is granted and `nx_i` is 0.
- R7: `acc_i` encodes 0 = read, 1 = write, 2 = execute, and 3 always faults.
  - Status 0 (granted) is reported when the matching right is present; otherwise status 1 (protection fault) is reported.
  - A fault in the primary group ends the search without any secondary read.
- R8: When neither group holds a match, status 2 is reported after exactly 32 word reads, with `pte1_o` and `prot_o` equal to zero.
- R9: `done_o` is high for exactly one cycle per accepted request. A request is accepted only while `req_ready_o` is high, which is only when the block is idle; `req_valid_i` asserted during a search has no effect.
- R10: `mem_req_valid_o` stays high with `mem_req_addr_o` unchanged until `mem_req_ready_i` is seen. No new read is issued before the previous read's response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Start a lookup |
| req_ready_o | output | 1 | Block is idle and accepts a lookup |
| hash_i | input | HASH_W | Primary hash value |
| tag_i | input | 30 | Compare tag {VSID, abbreviated page index} |
| tbl_base_i | input | ADDR_W | Table base byte address |
| tbl_mask_i | input | HASH_W | Mask applied to the hash |
| key_i | input | 1 | Protection key |
| nx_i | input | 1 | No-execute flag |
| acc_i | input | 2 | Access type |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result pulse |
| status_o | output | 2 | 0 granted, 1 protection fault, 2 not found |
| pte1_o | output | 32 | Word 1 of the matched entry |
| prot_o | output | 3 | Computed rights {X, W, R} |

## Verification
The decision on the last primary entry can coincide in one compare cycle with the switch to the secondary group: a match at index 7 must finish the search, and a non-match there must restart at the complemented hash. The bench provokes both outcomes. One test places a match at primary index 7. Another places entries that satisfy the tag but carry the wrong group flag or a clear valid bit, followed by a secondary match at index 7. Each outcome is judged by the exact number and addresses of the reads issued. A second collision is a permission fault in the primary group while a granting entry waits in the secondary group. This case is judged by the fault status and a read count of two.

// File: rtl/hpt_pkg.sv
// Shared definitions for the hashed page table searcher.
// Assumes 32-bit entry words; entry layout is fixed by the table format.
package hpt_pkg;

    localparam int PTE_W   = 32;
    localparam int VSID_W  = 24;
    localparam int API_W   = 6;
    localparam int TAG_W   = VSID_W + API_W;
    localparam int PROT_W  = 3;

    localparam int VALID_BIT = 31;
    localparam int GROUP_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ0,
        ST_WAIT0,
        ST_REQ1,
        ST_WAIT1,
        ST_CMP
    } srch_state_e;

    localparam logic [1:0] STAT_GRANT = 2'd0;
    localparam logic [1:0] STAT_FAULT = 2'd1;
    localparam logic [1:0] STAT_MISS  = 2'd2;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // Rights {X, W, R} from key, PP field and no-execute flag.
    function automatic logic [PROT_W-1:0] pp_rights(input logic key,
                                                    input logic [1:0] pp,
                                                    input logic nx);
        logic rd, wr;
        if (!key) begin
            rd = 1'b1;
            wr = (pp != 2'd3);
        end else begin
            rd = (pp != 2'd0);
            wr = (pp == 2'd2);
        end
        return {rd & ~nx, wr, rd};
    endfunction

endpackage

// File: rtl/hpt_entry_addr.sv
// Entry address generator: forms the byte address of one word of one entry.
// Assumes groups are ENTRIES entries of two 32-bit words, aligned to their size.
module hpt_entry_addr #(
    parameter int ADDR_W  = 32,
    parameter int HASH_W  = 19,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [HASH_W-1:0] mask_i,
    input  logic [HASH_W-1:0] hash_i,
    input  logic              sec_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              word_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int ENTRY_SHIFT = 3;
    localparam int GROUP_SHIFT = $clog2(ENTRIES) + ENTRY_SHIFT;

    logic [HASH_W-1:0] grp_sel;

    // Choose the primary or complemented hash and apply the table mask.
    always_comb grp_sel = (sec_i ? ~hash_i : hash_i) & mask_i;

    // Sum base, group offset, entry offset and word offset.
    always_comb addr_o = base_i
                       + (ADDR_W'(grp_sel) << GROUP_SHIFT)
                       + (ADDR_W'(idx_i) << ENTRY_SHIFT)
                       + (word_i ? ADDR_W'(4) : ADDR_W'(0));
endmodule

// File: rtl/hpt_entry_match.sv
// Entry matcher: decides whether word 0 of an entry hits the requested tag
// in the group currently scanned. Purely combinational.
module hpt_entry_match
    import hpt_pkg::*;
(
    input  logic [PTE_W-1:0] w0_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             sec_i,
    output logic             hit_o
);
    logic [TAG_W-1:0] entry_tag;

    // Gather the compare field around the group flag bit.
    always_comb entry_tag = {w0_i[VALID_BIT-1:GROUP_BIT+1], w0_i[GROUP_BIT-1:0]};

    // Valid, right group, and equal compare field.
    always_comb hit_o = w0_i[VALID_BIT] && (w0_i[GROUP_BIT] == sec_i) && (entry_tag == tag_i);
endmodule

// File: rtl/hpt_access_check.sv
// Access checker: computes rights from the PP field and judges the request.
// Assumes access code 3 is reserved and always denied.
module hpt_access_check
    import hpt_pkg::*;
(
    input  logic [1:0]        pp_i,
    input  logic              key_i,
    input  logic              nx_i,
    input  logic [1:0]        acc_i,
    output logic [PROT_W-1:0] prot_o,
    output logic              grant_o
);
    // Rights for this entry.
    always_comb prot_o = pp_rights(key_i, pp_i, nx_i);

    // Select the right that the access type needs.
    always_comb begin
        unique case (acc_i)
            ACC_READ:  grant_o = prot_o[0];
            ACC_WRITE: grant_o = prot_o[1];
            ACC_EXEC:  grant_o = prot_o[2];
            default:   grant_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hpt_group_search.sv
// Hashed page table group searcher (top).
// Scans the primary group, then the secondary group only on a full miss,
// stopping at the first matching entry. Reads go one at a time through a
// valid/ready request port; responses are assumed to arrive only for the
// single outstanding read.
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int HASH_W  = 19,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [HASH_W-1:0] hash_i,
    input  logic [29:0]       tag_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [HASH_W-1:0] tbl_mask_i,
    input  logic              key_i,
    input  logic              nx_i,
    input  logic [1:0]        acc_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [31:0]       mem_rsp_data_i,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [31:0]       pte1_o,
    output logic [2:0]        prot_o
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    srch_state_e       state_q;
    logic [HASH_W-1:0] hash_q, mask_q;
    logic [ADDR_W-1:0] base_q;
    logic [TAG_W-1:0]  tag_q;
    logic              key_q, nx_q;
    logic [1:0]        acc_q;
    logic              sec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PTE_W-1:0]  w0_q, w1_q;

    logic              hit;
    logic              grant;
    logic [PROT_W-1:0] rights;

    hpt_entry_addr #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .ENTRIES(ENTRIES)) u_addr (
        .base_i (base_q),
        .mask_i (mask_q),
        .hash_i (hash_q),
        .sec_i  (sec_q),
        .idx_i  (idx_q),
        .word_i (state_q == ST_REQ1),
        .addr_o (mem_req_addr_o)
    );

    hpt_entry_match u_match (
        .w0_i  (w0_q),
        .tag_i (tag_q),
        .sec_i (sec_q),
        .hit_o (hit)
    );

    hpt_access_check u_acc (
        .pp_i    (w1_q[1:0]),
        .key_i   (key_q),
        .nx_i    (nx_q),
        .acc_i   (acc_q),
        .prot_o  (rights),
        .grant_o (grant)
    );

    // Idle means ready; a read is requested in either request state.
    always_comb req_ready_o     = (state_q == ST_IDLE);
    always_comb mem_req_valid_o = (state_q == ST_REQ0) || (state_q == ST_REQ1);

    // Search sequencer: latch request, fetch words, compare, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hash_q   <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            tag_q    <= '0;
            key_q    <= 1'b0;
            nx_q     <= 1'b0;
            acc_q    <= '0;
            sec_q    <= 1'b0;
            idx_q    <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
            done_o   <= 1'b0;
            status_o <= STAT_GRANT;
            pte1_o   <= '0;
            prot_o   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid_i) begin
                    hash_q  <= hash_i;
                    mask_q  <= tbl_mask_i;
                    base_q  <= tbl_base_i;
                    tag_q   <= tag_i;
                    key_q   <= key_i;
                    nx_q    <= nx_i;
                    acc_q   <= acc_i;
                    sec_q   <= 1'b0;
                    idx_q   <= '0;
                    state_q <= ST_REQ0;
                end
                ST_REQ0:  if (mem_req_ready_i) state_q <= ST_WAIT0;
                ST_WAIT0: if (mem_rsp_valid_i) begin
                    w0_q    <= mem_rsp_data_i;
                    state_q <= ST_REQ1;
                end
                ST_REQ1:  if (mem_req_ready_i) state_q <= ST_WAIT1;
                ST_WAIT1: if (mem_rsp_valid_i) begin
                    w1_q    <= mem_rsp_data_i;
                    state_q <= ST_CMP;
                end
                ST_CMP: begin
                    if (hit) begin
                        done_o   <= 1'b1;
                        status_o <= grant ? STAT_GRANT : STAT_FAULT;
                        pte1_o   <= w1_q;
                        prot_o   <= rights;
                        state_q  <= ST_IDLE;
                    end else if (idx_q != LAST_IDX) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_REQ0;
                    end else if (!sec_q) begin
                        sec_q   <= 1'b1;
                        idx_q   <= '0;
                        state_q <= ST_REQ0;
                    end else begin
                        done_o   <= 1'b1;
                        status_o <= STAT_MISS;
                        pte1_o   <= '0;
                        prot_o   <= '0;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: reset always leaves the block idle with no pulse.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready_o && !done_o));

    // R10: a pending request holds its address until taken.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R10: data only arrives while a single read is outstanding.
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid_i |-> (state_q == ST_WAIT0 || state_q == ST_WAIT1));

    // R2: every read is word aligned.
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));

    // R9: result is a single-cycle pulse with a legal status.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o != 2'd3));

    // R6: exec right never appears without read right.
    a_r6_exec_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && prot_o[2]) |-> prot_o[0]);

    // R9: no memory traffic while idle.
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_valid_o);
endmodule

// File: tb/hpt_group_search_tb.sv
// Directed bench for the hashed page table group searcher.
module hpt_group_search_tb_top;
    localparam int ADDR_W = 32;
    localparam int HASH_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [HASH_W-1:0] hash = '0;
    logic [29:0]       tag = '0;
    logic [ADDR_W-1:0] base = '0;
    logic [HASH_W-1:0] mask = '0;
    logic              key = 1'b0, nx = 1'b0;
    logic [1:0]        acc = '0;
    logic              mreq_v, mreq_rdy;
    logic [ADDR_W-1:0] mreq_a;
    logic              mrsp_v;
    logic [31:0]       mrsp_d;
    logic              done;
    logic [1:0]        status;
    logic [31:0]       pte1;
    logic [2:0]        prot;

    always #2.5 clk = ~clk;

    hpt_group_search #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .hash_i(hash), .tag_i(tag), .tbl_base_i(base), .tbl_mask_i(mask),
        .key_i(key), .nx_i(nx), .acc_i(acc),
        .mem_req_valid_o(mreq_v), .mem_req_ready_i(mreq_rdy), .mem_req_addr_o(mreq_a),
        .mem_rsp_valid_i(mrsp_v), .mem_rsp_data_i(mrsp_d),
        .done_o(done), .status_o(status), .pte1_o(pte1), .prot_o(prot)
    );

    // Memory model: 64 words, one-cycle response, optional ready stalls.
    logic [31:0] mem [0:63];
    logic [31:0] rd_log [0:63];
    int          nreads = 0;
    int          ndone = 0;
    logic        stall = 1'b0;
    logic        rdy_q;

    always_comb mreq_rdy = rdy_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b1;
            mrsp_v <= 1'b0;
            mrsp_d <= '0;
        end else begin
            rdy_q  <= stall ? ~rdy_q : 1'b1;
            mrsp_v <= 1'b0;
            if (mreq_v && mreq_rdy) begin
                mrsp_v <= 1'b1;
                mrsp_d <= mem[mreq_a[7:2]];
                rd_log[nreads[5:0]] <= mreq_a;
                nreads <= nreads + 1;
            end
            if (done) ndone <= ndone + 1;
        end
    end

    int tests = 0, fails = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_w0(input logic v, input logic h, input logic [29:0] t);
        return {v, t[29:6], h, t[5:0]};
    endfunction

    // Expected rights {X,W,R} from the requirement table.
    function automatic logic [2:0] exp_rights(input logic k, input logic [1:0] pp, input logic n);
        logic r, w;
        if (!k) begin r = 1'b1; w = (pp != 2'd3); end
        else begin r = (pp != 2'd0); w = (pp == 2'd2); end
        return {r & ~n, w, r};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    // Place an entry in group g (64-byte groups, base 0), index i.
    task automatic put(input int g, input int i, input logic [31:0] w0, input logic [31:0] w1);
        mem[g*16 + i*2]     = w0;
        mem[g*16 + i*2 + 1] = w1;
    endtask

    logic [1:0]  r_stat;
    logic [31:0] r_pte1;
    logic [2:0]  r_prot;
    int          r_reads, r_start, r_dones;

    // Issue one lookup and wait for its result; optionally poke req_valid while busy.
    task automatic lookup(input logic [HASH_W-1:0] h, input logic [HASH_W-1:0] m,
                          input logic [29:0] t, input logic k, input logic n,
                          input logic [1:0] a, input bit poke);
        int d0;
        @(negedge clk);
        r_start = nreads;
        d0 = ndone;
        hash = h; mask = m; tag = t; key = k; nx = n; acc = a; base = '0;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            hash = h ^ 19'h3; tag = ~t;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
        r_stat = status; r_pte1 = pte1; r_prot = prot;
        repeat (4) @(negedge clk);
        r_reads = nreads - r_start;
        r_dones = ndone - d0;
    endtask

    function automatic logic [31:0] log_at(input int k);
        return rd_log[(r_start + k) % 64];
    endfunction

    localparam logic [29:0] TAG_A = 30'h1234_5678 & 30'h3FFF_FFFF;

    task automatic t_reset();
        chk("R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
    endtask

    task automatic t_primary_hit();
        clear_mem();
        put(1, 0, mk_w0(1, 0, TAG_A ^ 30'h1), 32'h0);
        put(1, 2, mk_w0(1, 0, TAG_A), 32'hABCD_E002);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd0, 0);
        chk("R4", "primary hit status", r_stat, 0);
        chk("R5", "primary hit pte1", r_pte1, 32'hABCD_E002);
        chk("R6", "primary hit prot", r_prot, exp_rights(0, 2, 0));
        chk("R5", "reads up to idx2", r_reads, 6);
        chk("R2", "first read addr", log_at(0), 32'h40);
        chk("R2", "word1 of idx0", log_at(1), 32'h44);
        chk("R2", "word1 of idx2", log_at(5), 32'h54);
        chk("R9", "single done", r_dones, 1);
    endtask

    task automatic t_first_match();
        clear_mem();
        put(1, 1, mk_w0(1, 0, TAG_A), 32'h1111_1002);
        put(1, 4, mk_w0(1, 0, TAG_A), 32'h2222_2000);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd1, 0);
        chk("R5", "first match pte1", r_pte1, 32'h1111_1002);
        chk("R5", "no read past idx1", r_reads, 4);
    endtask

    task automatic t_last_primary();
        clear_mem();
        put(1, 7, mk_w0(1, 0, TAG_A), 32'h7777_7001);
        put(2, 0, mk_w0(1, 1, TAG_A), 32'h8888_8002);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd0, 0);
        chk("R5", "idx7 hit pte1", r_pte1, 32'h7777_7001);
        chk("R3", "idx7 hit no secondary reads", r_reads, 16);
    endtask

    task automatic t_fault_stays();
        clear_mem();
        put(1, 0, mk_w0(1, 0, TAG_A), 32'h5555_5000);
        put(2, 0, mk_w0(1, 1, TAG_A), 32'h6666_6002);
        lookup(19'd5, 19'd3, TAG_A, 1, 0, 2'd1, 0);
        chk("R7", "primary fault status", r_stat, 1);
        chk("R7", "fault pte1 kept", r_pte1, 32'h5555_5000);
        chk("R6", "key1 pp0 prot", r_prot, 3'b000);
        chk("R7", "fault reads no secondary", r_reads, 2);
    endtask

    task automatic t_secondary();
        clear_mem();
        put(1, 0, mk_w0(0, 0, TAG_A), 32'h0);
        put(1, 1, mk_w0(1, 1, TAG_A), 32'h0);
        put(1, 2, mk_w0(1, 0, TAG_A ^ 30'h80), 32'h0);
        put(2, 7, mk_w0(1, 1, TAG_A), 32'h9999_9001);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd1, 0);
        chk("R3", "secondary status", r_stat, 0);
        chk("R4", "secondary pte1", r_pte1, 32'h9999_9001);
        chk("R3", "secondary read count", r_reads, 32);
        chk("R3", "secondary first addr", log_at(16), 32'h80);
        chk("R2", "secondary last addr", log_at(31), 32'hBC);
    endtask

    task automatic t_miss();
        clear_mem();
        put(2, 3, mk_w0(1, 0, TAG_A), 32'h1);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd0, 0);
        chk("R8", "miss status", r_stat, 2);
        chk("R8", "miss reads", r_reads, 32);
        chk("R8", "miss pte1", r_pte1, 0);
        chk("R8", "miss prot", r_prot, 0);
    endtask

    task automatic t_rights();
        clear_mem();
        put(1, 0, mk_w0(1, 0, TAG_A), 32'h0000_0002);
        lookup(19'd5, 19'd3, TAG_A, 0, 1, 2'd2, 0);
        chk("R7", "nx exec fault", r_stat, 1);
        chk("R6", "nx prot", r_prot, exp_rights(0, 2, 1));
        put(1, 0, mk_w0(1, 0, TAG_A), 32'h0000_0003);
        lookup(19'd5, 19'd3, TAG_A, 1, 0, 2'd1, 0);
        chk("R7", "key1 pp3 write fault", r_stat, 1);
        chk("R6", "key1 pp3 prot", r_prot, exp_rights(1, 3, 0));
        lookup(19'd5, 19'd3, TAG_A, 1, 0, 2'd2, 0);
        chk("R7", "key1 pp3 exec grant", r_stat, 0);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd3, 0);
        chk("R7", "reserved access faults", r_stat, 1);
    endtask

    task automatic t_mask_and_stall();
        clear_mem();
        put(1, 2, mk_w0(1, 0, TAG_A), 32'hCAFE_0001);
        stall = 1'b1;
        lookup(19'h7FFF5, 19'd3, TAG_A, 0, 0, 2'd1, 0);
        stall = 1'b0;
        chk("R10", "stalled status", r_stat, 0);
        chk("R2", "masked hash addr", log_at(0), 32'h40);
        chk("R10", "stalled read count", r_reads, 6);
        clear_mem();
        put(0, 3, mk_w0(1, 1, TAG_A), 32'hBEEF_0002);
        lookup(19'd5, 19'd0, TAG_A, 0, 0, 2'd0, 0);
        chk("R3", "mask0 secondary group0 pte1", r_pte1, 32'hBEEF_0002);
        chk("R3", "mask0 secondary start addr", log_at(16), 32'h0);
        chk("R3", "mask0 reads", r_reads, 24);
    endtask

    task automatic t_busy_ignore();
        clear_mem();
        put(1, 2, mk_w0(1, 0, TAG_A), 32'hD00D_0002);
        lookup(19'd5, 19'd3, TAG_A, 0, 0, 2'd0, 1);
        chk("R9", "busy poke result", r_pte1, 32'hD00D_0002);
        chk("R9", "busy poke one done", r_dones, 1);
        chk("R9", "busy poke reads", r_reads, 6);
        chk("R9", "idle again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_hit();
        t_first_match();
        t_last_primary();
        t_fault_stays();
        t_secondary();
        t_miss();
        t_rights();
        t_mask_and_stall();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule